// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block sits in front of a serial flash controller that serves several chip selects from one memory-mapped region. Each chip select owns one segment register that gives a window in that region, counted in 1 MB blocks: the first block and the last block of the window, both inclusive. A bus address arrives as an offset from the region base, together with a valid strobe. One clock later the block reports which chip select the address falls in, as a one-hot vector, and the offset of the address inside that window. If no window claims the address, it raises a miss flag instead.

Software programs the segment registers through a simple write/read port. A register that holds all zeros switches its window off. At reset the windows are laid out one after another from the region base, with a fixed minimum size each. When a programming error makes windows overlap, the lowest-numbered chip select takes the access and an overlap flag is raised. The block does not try to resolve the overlap any further.

Top module: `cs_win_decoder`

## Requirements
- R1: After reset, chip select i holds a window that starts at block i*MIN_WIN_MB and is MIN_WIN_MB blocks long. With the defaults the registers read 0x0010_0000, 0x0030_0020 and 0x0050_0040.
- R2: In a segment register, bits [11:4] hold the first 1 MB block of the window (offset bits [27:20]) and bits [27:20] hold the last block, inclusive. All other bits are not stored and read as zero. `reg_rdata` shows the register picked by `reg_sel` without delay, and a write takes effect at the clock edge.
- R3: A write with `reg_sel` at NUM_CS or above changes no register. A read at such a selector returns zero.
- R4: An address with `addr_valid` high hits chip select i when first_i <= addr[27:20] <= last_i. The result appears on `cs_hit` one cycle later. A window whose first block is above its last block matches nothing.
- R5: A segment register that holds zero matches no address.
- R6: On a hit, `win_offset` equals addr minus first*1 MB of the winning window. Otherwise it is zero.
- R7: `cs_miss` is set one cycle after a valid address that no window matches. When the previous cycle had `addr_valid` low, `cs_hit`, `cs_miss`, `cs_overlap` and `win_offset` are all zero.
- R8: When several windows match, only the lowest-numbered one is set in `cs_hit`, and `cs_overlap` is raised. `cs_hit` never has more than one bit set.
- R9: `out_valid` repeats `addr_valid` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Segment register write strobe |
| reg_sel | input | SEL_W | Segment register selector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| addr_valid | input | 1 | Address strobe |
| addr | input | 28 | Address offset from the region base |
| out_valid | output | 1 | Decode result valid |
| cs_hit | output | NUM_CS | One-hot chip-select hit |
| cs_miss | output | 1 | Valid address matched no window |
| cs_overlap | output | 1 | More than one window matched |
| win_offset | output | 28 | Offset inside the winning window |

## Verification
The hardest states to reach are the ones that only a faulty program creates: overlapping windows, windows whose bounds are inverted, and registers written to zero. The ordinary reset layout never produces them. The stimulus rewrites registers on purpose to create each case. It then sends addresses at the exact first and last megabyte of each window. After that, a long random phase mixes register writes, some with garbage in the unused bits, with addresses biased into the low 16 MB, so that random windows get hit often.

// File: rtl/cswin_pkg.sv
package cswin_pkg;
  localparam int REG_W     = 32;
  localparam int MB_SHIFT  = 20;
  localparam int MB_W      = 8;
  localparam int OFS_W     = MB_SHIFT + MB_W;
  localparam int FIRST_LSB = 4;
  localparam int LAST_LSB  = 20;
  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'((1 << MB_W) - 1) << FIRST_LSB) | (REG_W'((1 << MB_W) - 1) << LAST_LSB);

  typedef logic [MB_W-1:0] mb_t;

  function automatic logic [REG_W-1:0] seg_reset(input int idx, input int min_mb);
    mb_t first_mb;
    mb_t last_mb;
    first_mb = mb_t'(idx * min_mb);
    last_mb  = mb_t'(idx * min_mb + min_mb - 1);
    return (REG_W'(last_mb) << LAST_LSB) | (REG_W'(first_mb) << FIRST_LSB);
  endfunction
endpackage

// File: rtl/cswin_regs.sv
module cswin_regs
  import cswin_pkg::*;
#(
  parameter int NUM_CS     = 3,
  parameter int MIN_WIN_MB = 2,
  parameter int SEL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEL_W-1:0]              sel,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_CS-1:0][REG_W-1:0]  seg
);
  logic [NUM_CS-1:0][REG_W-1:0] seg_d;
  logic [NUM_CS-1:0]            wr_en;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
    assign wr_en[i] = we && (int'(sel) == i);

    always_comb begin
      seg_d[i] = seg[i];
      if (wr_en[i]) seg_d[i] = wdata & FIELD_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg[i] <= seg_reset(i, MIN_WIN_MB);
      else        seg[i] <= seg_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (int'(sel) == i) rdata = seg[i];
  end
endmodule

// File: rtl/cswin_match.sv
module cswin_match
  import cswin_pkg::*;
(
  input  logic [REG_W-1:0] seg,
  input  mb_t              mb,
  output logic             match,
  output mb_t              first_mb
);
  mb_t last_mb;

  assign first_mb = seg[FIRST_LSB +: MB_W];
  assign last_mb  = seg[LAST_LSB +: MB_W];
  assign match    = (seg != '0) && (mb >= first_mb) && (mb <= last_mb);
endmodule

// File: rtl/cs_win_decoder.sv
module cs_win_decoder
  import cswin_pkg::*;
#(
  parameter int NUM_CS     = 3,
  parameter int MIN_WIN_MB = 2,
  parameter int SEL_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              addr_valid,
  input  logic [27:0]       addr,
  output logic              out_valid,
  output logic [NUM_CS-1:0] cs_hit,
  output logic              cs_miss,
  output logic              cs_overlap,
  output logic [27:0]       win_offset
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [NUM_CS-1:0][REG_W-1:0] seg;

  cswin_regs #(.NUM_CS(NUM_CS), .MIN_WIN_MB(MIN_WIN_MB), .SEL_W(SEL_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .seg   (seg)
  );

  logic [NUM_CS-1:0] match;
  mb_t               first_mb [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    cswin_match u_cmp (
      .seg      (seg[i]),
      .mb       (addr[OFS_W-1:MB_SHIFT]),
      .match    (match[i]),
      .first_mb (first_mb[i])
    );
  end

  logic [NUM_CS-1:0] pick;
  mb_t               pick_base;
  logic              any_hit;
  logic              multi_hit;

  always_comb begin
    pick      = '0;
    pick_base = '0;
    any_hit   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (match[i] && !any_hit) begin
        pick[i]   = 1'b1;
        pick_base = first_mb[i];
        any_hit   = 1'b1;
      end
    end
    multi_hit = (match & (match - 1'b1)) != '0;
  end

  logic              val_d;
  logic [NUM_CS-1:0] hit_d;
  logic              miss_d;
  logic              ovl_d;
  logic [OFS_W-1:0]  ofs_d;

  always_comb begin
    val_d  = addr_valid;
    hit_d  = '0;
    miss_d = 1'b0;
    ovl_d  = 1'b0;
    ofs_d  = '0;
    if (addr_valid) begin
      hit_d  = pick;
      miss_d = !any_hit;
      ovl_d  = multi_hit;
      if (any_hit) ofs_d = addr - {pick_base, {MB_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid  <= 1'b0;
      cs_hit     <= '0;
      cs_miss    <= 1'b0;
      cs_overlap <= 1'b0;
      win_offset <= '0;
    end else begin
      out_valid  <= val_d;
      cs_hit     <= hit_d;
      cs_miss    <= miss_d;
      cs_overlap <= ovl_d;
      win_offset <= ofs_d;
    end
  end
endmodule

// File: rtl/cs_win_decoder_chk.sv
module cs_win_decoder_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic [31:0]       reg_rdata,
  input logic              out_valid,
  input logic [NUM_CS-1:0] cs_hit,
  input logic              cs_miss,
  input logic              cs_overlap,
  input logic [27:0]       win_offset
);
  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_hit));

  // R7
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_miss |-> (cs_hit == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (cs_hit == '0 && !cs_miss && !cs_overlap && win_offset == '0));

  // R8
  overlap_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_overlap |-> (cs_hit != '0));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> out_valid);

  // R2
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 32'hF00F_F00F) == 32'h0);
endmodule

bind cs_win_decoder cs_win_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .reg_rdata  (reg_rdata),
  .out_valid  (out_valid),
  .cs_hit     (cs_hit),
  .cs_miss    (cs_miss),
  .cs_overlap (cs_overlap),
  .win_offset (win_offset)
);

// File: tb/sim_cs_win_decoder.sv
module sim_cs_win_decoder;
  localparam int NCS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        addr_valid;
  logic [27:0] addr;
  logic        out_valid;
  logic [2:0]  cs_hit;
  logic        cs_miss;
  logic        cs_overlap;
  logic [27:0] win_offset;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  cs_win_decoder u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_valid(addr_valid),
    .addr(addr), .out_valid(out_valid), .cs_hit(cs_hit), .cs_miss(cs_miss),
    .cs_overlap(cs_overlap), .win_offset(win_offset)
  );

  logic [31:0] mreg [NCS];
  logic [2:0]  e_hit;
  logic        e_miss, e_ovl, e_val;
  logic [27:0] e_off;
  logic [31:0] e_rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_decode(input logic av, input logic [27:0] a);
    int cnt = 0;
    e_hit = '0; e_miss = 1'b0; e_ovl = 1'b0; e_off = '0; e_val = av;
    if (av) begin
      for (int i = 0; i < NCS; i++) begin
        int f = (mreg[i] >> 4) & 255;
        int l = (mreg[i] >> 20) & 255;
        int m = a >> 20;
        if (mreg[i] != 0 && f <= m && m <= l) begin
          if (cnt == 0) begin
            e_hit[i] = 1'b1;
            e_off = a - (28'(f) << 20);
          end
          cnt++;
        end
      end
      e_miss = (cnt == 0);
      e_ovl  = (cnt > 1);
    end
  endtask

  // Drive one cycle of inputs, advance, compare every output with the model.
  task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                      input logic av, input logic [27:0] a);
    reg_we = we; reg_sel = sel; reg_wdata = wd; addr_valid = av; addr = a;
    model_decode(av, a);
    if (we && sel < NCS) mreg[sel] = wd & 32'h0FF0_0FF0;
    e_rd = (sel < NCS) ? mreg[sel] : 32'h0;
    @(negedge clk);
    cyc++;
    check("R9 out_valid", 32'(out_valid), 32'(e_val));
    check("R4 cs_hit", 32'(cs_hit), 32'(e_hit));
    check("R7 cs_miss", 32'(cs_miss), 32'(e_miss));
    check("R8 cs_overlap", 32'(cs_overlap), 32'(e_ovl));
    check("R6 win_offset", 32'(win_offset), 32'(e_off));
    check("R2 reg_rdata", reg_rdata, e_rd);
  endtask

  initial begin
    int limit = 100000;
    while (cyc < limit) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, limit);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    addr_valid = 1'b0; addr = '0;
    mreg[0] = 32'h0010_0000; mreg[1] = 32'h0030_0020; mreg[2] = 32'h0050_0040;
    repeat (3) @(negedge clk);
    check("R7 reset hit", 32'(cs_hit), 32'h0);
    check("R9 reset out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset layout of the three windows
    reg_sel = 2'd0; #1 check("R1 seg0", reg_rdata, 32'h0010_0000);
    reg_sel = 2'd1; #1 check("R1 seg1", reg_rdata, 32'h0030_0020);
    reg_sel = 2'd2; #1 check("R1 seg2", reg_rdata, 32'h0050_0040);
    // R3: selector beyond the last chip select reads zero
    reg_sel = 2'd3; #1 check("R3 sel3 read", reg_rdata, 32'h0);

    // R4 / R6: window edges of the reset layout
    step(0, 0, 0, 1, 28'h000_0000);
    step(0, 0, 0, 1, 28'h01F_FFFF);
    step(0, 0, 0, 1, 28'h020_0000);
    step(0, 0, 0, 1, 28'h03F_FFFF);
    step(0, 0, 0, 1, 28'h05F_FFFF);
    step(0, 0, 0, 1, 28'h060_0000);   // R7 miss
    step(0, 0, 0, 0, 28'h020_0000);   // R7 idle
    // R3: write to unused selector changes nothing
    step(1, 3, 32'hFFFF_FFFF, 1, 28'h030_0000);
    step(0, 3, 0, 1, 28'h050_0000);
    check("R3 seg1 intact", 32'(mreg[1]), 32'h0030_0020);
    // R5: zeroed window matches nothing
    step(1, 1, 32'h0, 0, 0);
    step(0, 1, 0, 1, 28'h025_0000);
    check("R5 zero segment miss", 32'(cs_miss), 32'h1);
    // R2: unused bits dropped on write
    step(1, 1, 32'hFFFF_FFFF, 0, 0);
    step(0, 1, 0, 1, 28'hFF8_1234);
    check("R2 masked readback", reg_rdata, 32'h0FF0_0FF0);
    // R8: overlap, lowest chip select wins
    step(1, 2, 32'h0070_0000, 0, 0);
    step(0, 2, 0, 1, 28'h010_0000);
    check("R8 overlap winner", 32'(cs_hit), 32'h1);
    step(0, 2, 0, 1, 28'h030_0000);
    // R4: inverted bounds match nothing
    step(1, 0, 32'h0030_0050, 0, 0);
    step(0, 0, 0, 1, 28'h040_0000);
    check("R4 inverted window skipped", 32'(cs_hit), 32'h4);

    for (int k = 0; k < 400; k++) begin
      logic we = (($urandom % 6) == 0);
      logic [31:0] wd = $urandom;
      if (($urandom % 2) == 0) wd = wd & 32'h00F0_00F0;
      step(we, 2'($urandom % 4), wd, 1'($urandom % 4 != 0),
           28'($urandom % (16 << 20)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule